// File: doc/BRIEF.md
# Momentum Tail Clipper

This block is a post-processing stage placed after a momentum lookup in a muon track trigger. With each candidate it takes the lookup's momentum code and a set of track variables, for example the angular bend between the first two stations. For each variable it checks whether the value lies outside the range expected for that momentum. When it does, the stage proposes a lower momentum: the most probable momentum for that variable value. The reported momentum is the smallest of the original value and all proposals. A flag shows whether the result was lowered.

A two-bit mode selects the containment level. Mode 0 turns clipping off. Modes 1, 2 and 3 select bound sets tuned for 95%, 90% and 85% containment. The 90% set costs about 6% efficiency and the 85% set about 10%, in return for a lower trigger rate. Tail bounds are stored per variable, per bound set and per momentum bin. Most-probable-value tables are stored per variable and indexed by the variable value. Both are loaded through simple write ports before traffic and held in small synchronous RAMs. A candidate can be accepted on every cycle, and results leave in order after a fixed latency.

Top module: `tail_clipper`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid is 0.
- R2: Each accepted candidate (in_valid high at a clock edge) produces exactly one out_valid pulse LAT = clog2(NVAR)+2 cycles later (6 for the default NVAR of 10). Results keep their order.
- R3: In mode 0 the output momentum equals the input momentum and out_clip is 0, whatever the variables are.
- R4: For modes 1..3, variable j is in the tail when its unsigned value is below the lower bound or above the upper bound. The bounds are stored for variable j, bound set (mode-1) and momentum bin in_pt[PW-1:PW-PBW]. A value equal to either bound is inside.
- R5: A variable in the tail proposes the stored most-probable momentum for its own index and value, but only when that value is below the input momentum. A stored value that is equal or higher leaves the input momentum in place, so the output never exceeds the input.
- R6: The output momentum is the minimum of the input momentum and every proposal from the variables in the tail.
- R7: out_clip is 1 exactly when the output momentum is lower than the input momentum.
- R8: Each of modes 1, 2 and 3 uses only its own bound set. The set loaded with bnd_set = mode-1 governs that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd_we | input | 1 | Write strobe for a tail-bound entry |
| bnd_set | input | 2 | Bound set written (0..2, used by mode 1..3) |
| bnd_bin | input | PBW | Momentum bin written |
| bnd_var | input | clog2(NVAR) | Variable index written |
| bnd_lo | input | VW | Lower bound (inclusive) |
| bnd_hi | input | VW | Upper bound (inclusive) |
| mpv_we | input | 1 | Write strobe for a most-probable-momentum entry |
| mpv_var | input | clog2(NVAR) | Variable index written |
| mpv_idx | input | VW | Variable value the entry belongs to |
| mpv_val | input | PW | Most probable momentum for that value |
| in_valid | input | 1 | Candidate present |
| in_mode | input | 2 | 0 off, 1 wide, 2 medium, 3 tight |
| in_pt | input | PW | Momentum from the lookup |
| in_vars | input | NVAR*VW | Variables, variable j in bits [j*VW +: VW] |
| out_valid | output | 1 | Result present |
| out_pt | output | PW | Clipped momentum |
| out_clip | output | 1 | Result was lowered |

## Verification
The bench aims at the exact bound values, where an off-by-one comparison would wrongly demote a variable sitting on the bound. It also tests the case of a proposal above the input, where a design that skips the comparison would raise the momentum. Several variables fall in the tail at once with different proposals, which exposes a minimum tree that drops a leaf or picks the wrong one. The same candidate runs in all three modes and in mode 0, which catches mixed-up bound sets or a disable that does not hold. Randomised back-to-back traffic with gaps checks that every result arrives exactly after the pipeline delay and in order.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    CLIP_OFF   = 2'd0,
    CLIP_WIDE  = 2'd1,
    CLIP_MID   = 2'd2,
    CLIP_TIGHT = 2'd3
  } clip_mode_e;

  // register stages of the minimum tree
  function automatic int tree_levels(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // RAM read stage + per-variable decision stage + tree
  function automatic int pipe_latency(input int n);
    return tree_levels(n) + 2;
  endfunction

endpackage

// File: rtl/tc_var_unit.sv
module tc_var_unit #(
  parameter int IDX = 0,
  parameter int VW  = 6,
  parameter int PW  = 8,
  parameter int PBW = 3,
  parameter int VIW = 4
) (
  input  logic           clk,
  input  logic           bnd_we,
  input  logic [1:0]     bnd_set,
  input  logic [PBW-1:0] bnd_bin,
  input  logic [VIW-1:0] bnd_var,
  input  logic [VW-1:0]  bnd_lo,
  input  logic [VW-1:0]  bnd_hi,
  input  logic           mpv_we,
  input  logic [VIW-1:0] mpv_var,
  input  logic [VW-1:0]  mpv_idx,
  input  logic [PW-1:0]  mpv_val,
  input  logic [VW-1:0]  rd_val,
  input  logic [1:0]     rd_set,
  input  logic [PBW-1:0] rd_bin,
  input  logic [PW-1:0]  pt_s1,
  input  logic           on_s1,
  output logic [PW-1:0]  cand,
  output logic           dem
);

  localparam int BDEPTH = 4 << PBW;
  localparam int MDEPTH = 1 << VW;
  localparam int BAW    = PBW + 2;

  logic [2*VW-1:0] bnd_mem [BDEPTH];
  logic [PW-1:0]   mpv_mem [MDEPTH];

  logic [2*VW-1:0] bnd_q;
  logic [PW-1:0]   mpv_q;
  logic [VW-1:0]   val_q;

  // bound table: one entry per (set, bin), {hi, lo}
  always_ff @(posedge clk) begin
    if (bnd_we && bnd_var == VIW'(IDX))
      bnd_mem[{bnd_set, bnd_bin}] <= {bnd_hi, bnd_lo};
  end

  always_ff @(posedge clk) begin
    bnd_q <= bnd_mem[BAW'({rd_set, rd_bin})];
  end

  // most probable momentum per variable value
  always_ff @(posedge clk) begin
    if (mpv_we && mpv_var == VIW'(IDX))
      mpv_mem[mpv_idx] <= mpv_val;
  end

  always_ff @(posedge clk) begin
    mpv_q <= mpv_mem[rd_val];
    val_q <= rd_val;
  end

  logic [VW-1:0] lo_b, hi_b;
  logic          in_tail, lowers;

  always_comb begin
    lo_b    = bnd_q[VW-1:0];
    hi_b    = bnd_q[2*VW-1:VW];
    in_tail = on_s1 && ((val_q < lo_b) || (val_q > hi_b));
    lowers  = in_tail && (mpv_q < pt_s1);
  end

  always_ff @(posedge clk) begin
    cand <= lowers ? mpv_q : pt_s1;
    dem  <= lowers;
  end

endmodule

// File: rtl/tc_min_tree.sv
module tc_min_tree #(
  parameter int N      = 10,
  parameter int W      = 8,
  parameter int LEVELS = 4
) (
  input  logic           clk,
  input  logic [N*W-1:0] in_val,
  input  logic [N-1:0]   in_flg,
  output logic [W-1:0]   out_val,
  output logic           out_flg
);

  localparam int P     = 1 << LEVELS;
  localparam int NODES = P - 1;
  localparam int ALL   = 2 * P - 1;

  logic [W-1:0] node_v [NODES];
  logic         node_f [NODES];
  logic [W-1:0] src_v  [ALL];
  logic         src_f  [ALL];

  // heap view: internal nodes first, then leaves padded with neutral values
  always_comb begin
    for (int k = 0; k < ALL; k++) begin
      if (k < NODES) begin
        src_v[k] = node_v[k];
        src_f[k] = node_f[k];
      end else if (k - NODES < N) begin
        src_v[k] = in_val[(k-NODES)*W +: W];
        src_f[k] = in_flg[k-NODES];
      end else begin
        src_v[k] = '1;
        src_f[k] = 1'b0;
      end
    end
  end

  // every internal node is a register stage
  always_ff @(posedge clk) begin
    for (int k = 0; k < NODES; k++) begin
      node_v[k] <= (src_v[2*k+2] < src_v[2*k+1]) ? src_v[2*k+2] : src_v[2*k+1];
      node_f[k] <= src_f[2*k+1] | src_f[2*k+2];
    end
  end

  assign out_val = node_v[0];
  assign out_flg = node_f[0];

endmodule

// File: rtl/tail_clipper.sv
module tail_clipper
  import tc_pkg::*;
#(
  parameter int NVAR = 10,
  parameter int VW   = 6,
  parameter int PW   = 8,
  parameter int PBW  = 3,
  parameter int VIW  = (NVAR > 1) ? $clog2(NVAR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bnd_we,
  input  logic [1:0]        bnd_set,
  input  logic [PBW-1:0]    bnd_bin,
  input  logic [VIW-1:0]    bnd_var,
  input  logic [VW-1:0]     bnd_lo,
  input  logic [VW-1:0]     bnd_hi,
  input  logic              mpv_we,
  input  logic [VIW-1:0]    mpv_var,
  input  logic [VW-1:0]     mpv_idx,
  input  logic [PW-1:0]     mpv_val,
  input  logic              in_valid,
  input  logic [1:0]        in_mode,
  input  logic [PW-1:0]     in_pt,
  input  logic [NVAR*VW-1:0] in_vars,
  output logic              out_valid,
  output logic [PW-1:0]     out_pt,
  output logic              out_clip
);

  localparam int LEVELS = tree_levels(NVAR);
  localparam int LAT    = pipe_latency(NVAR);

  clip_mode_e     mode_in;
  logic [1:0]     set_idx;
  logic [PBW-1:0] bin_idx;

  always_comb begin
    mode_in = clip_mode_e'(in_mode);
    set_idx = in_mode - 2'd1;
    bin_idx = in_pt[PW-1 -: PBW];
  end

  // stage 1: table reads
  logic          vld_s1, vld_s2;
  logic          on_s1;
  logic [PW-1:0] pt_s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_s1 <= 1'b0;
      vld_s2 <= 1'b0;
    end else begin
      vld_s1 <= in_valid;
      vld_s2 <= vld_s1;
    end
    pt_s1 <= in_pt;
    on_s1 <= (mode_in != CLIP_OFF);
  end

  // stage 2: per-variable tail decision
  logic [NVAR*PW-1:0] cand_all;
  logic [NVAR-1:0]    dem_all;

  for (genvar j = 0; j < NVAR; j++) begin : g_var
    tc_var_unit #(
      .IDX(j), .VW(VW), .PW(PW), .PBW(PBW), .VIW(VIW)
    ) u_var (
      .clk     (clk),
      .bnd_we  (bnd_we),
      .bnd_set (bnd_set),
      .bnd_bin (bnd_bin),
      .bnd_var (bnd_var),
      .bnd_lo  (bnd_lo),
      .bnd_hi  (bnd_hi),
      .mpv_we  (mpv_we),
      .mpv_var (mpv_var),
      .mpv_idx (mpv_idx),
      .mpv_val (mpv_val),
      .rd_val  (in_vars[j*VW +: VW]),
      .rd_set  (set_idx),
      .rd_bin  (bin_idx),
      .pt_s1   (pt_s1),
      .on_s1   (on_s1),
      .cand    (cand_all[j*PW +: PW]),
      .dem     (dem_all[j])
    );
  end

  // stages 3..: minimum tree
  tc_min_tree #(.N(NVAR), .W(PW), .LEVELS(LEVELS)) u_tree (
    .clk     (clk),
    .in_val  (cand_all),
    .in_flg  (dem_all),
    .out_val (out_pt),
    .out_flg (out_clip)
  );

  logic [LEVELS-1:0] vld_tree;

  always_ff @(posedge clk) begin
    if (rst) vld_tree <= '0;
    else     vld_tree <= {vld_tree[LEVELS-2:0], vld_s2};
  end

  assign out_valid = vld_tree[LEVELS-1];

endmodule

// File: rtl/tail_clipper_chk.sv
module tail_clipper_chk
  import tc_pkg::*;
#(
  parameter int PW   = 8,
  parameter int NVAR = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [1:0]    in_mode,
  input logic [PW-1:0] in_pt,
  input logic          out_valid,
  input logic [PW-1:0] out_pt,
  input logic          out_clip
);

  localparam int LAT = pipe_latency(NVAR);

  logic [LAT-1:0] v_sh;
  logic [PW-1:0]  pt_sh [LAT];
  logic [1:0]     md_sh [LAT];

  always_ff @(posedge clk) begin
    if (rst) v_sh <= '0;
    else     v_sh <= {v_sh[LAT-2:0], in_valid};
    pt_sh[0] <= in_pt;
    md_sh[0] <= in_mode;
    for (int k = 1; k < LAT; k++) begin
      pt_sh[k] <= pt_sh[k-1];
      md_sh[k] <= md_sh[k-1];
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_fixed_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_sh[LAT-1]);

  p_off_passes_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && md_sh[LAT-1] == 2'd0) |-> (out_pt == pt_sh[LAT-1] && !out_clip));

  p_never_raised_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_pt <= pt_sh[LAT-1]));

  p_flag_match_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_clip == (out_pt < pt_sh[LAT-1])));

endmodule

bind tail_clipper tail_clipper_chk #(.PW(PW), .NVAR(NVAR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_mode   (in_mode),
  .in_pt     (in_pt),
  .out_valid (out_valid),
  .out_pt    (out_pt),
  .out_clip  (out_clip)
);

// File: tb/tail_clipper_tb.sv
module tail_clipper_tb;

  localparam int NVAR = 10;
  localparam int VW   = 6;
  localparam int PW   = 8;
  localparam int PBW  = 3;
  localparam int VIW  = 4;
  localparam int LAT  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bnd_we = 0, mpv_we = 0, in_valid = 0;
  logic [1:0] bnd_set = 0, in_mode = 0;
  logic [PBW-1:0] bnd_bin = 0;
  logic [VIW-1:0] bnd_var = 0, mpv_var = 0;
  logic [VW-1:0] bnd_lo = 0, bnd_hi = 0, mpv_idx = 0;
  logic [PW-1:0] mpv_val = 0, in_pt = 0;
  logic [NVAR*VW-1:0] in_vars = '0;
  logic out_valid, out_clip;
  logic [PW-1:0] out_pt;

  always #4 clk = ~clk;

  tail_clipper #(.NVAR(NVAR), .VW(VW), .PW(PW), .PBW(PBW)) u_dut (.*);

  // bench copies of the tables
  logic [VW-1:0] m_lo [3][1<<PBW][NVAR];
  logic [VW-1:0] m_hi [3][1<<PBW][NVAR];
  logic [PW-1:0] m_mpv [NVAR][1<<VW];

  int cyc = 0, checks = 0, errors = 0;
  int q_cyc[$];
  logic [PW-1:0] q_pt[$];
  bit q_clip[$];
  string q_tag[$];

  always @(posedge clk) cyc++;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_bound(input int s, input int b, input int v, input int lo, input int hi);
    @(negedge clk);
    bnd_we = 1; bnd_set = 2'(s); bnd_bin = PBW'(b); bnd_var = VIW'(v);
    bnd_lo = VW'(lo); bnd_hi = VW'(hi);
    m_lo[s][b][v] = VW'(lo); m_hi[s][b][v] = VW'(hi);
    @(negedge clk); bnd_we = 0;
  endtask

  task automatic wr_mpv(input int v, input int idx, input int val);
    @(negedge clk);
    mpv_we = 1; mpv_var = VIW'(v); mpv_idx = VW'(idx); mpv_val = PW'(val);
    m_mpv[v][idx] = PW'(val);
    @(negedge clk); mpv_we = 0;
  endtask

  function automatic void model(input int mode, input logic [PW-1:0] pt,
                                input logic [NVAR*VW-1:0] vars,
                                output logic [PW-1:0] ep, output bit ec);
    int b;
    ep = pt;
    b = int'(pt[PW-1 -: PBW]);
    if (mode != 0) begin
      for (int j = 0; j < NVAR; j++) begin
        logic [VW-1:0] v;
        v = vars[j*VW +: VW];
        if (v < m_lo[mode-1][b][j] || v > m_hi[mode-1][b][j])
          if (m_mpv[j][v] < ep) ep = m_mpv[j][v];
      end
    end
    ec = (ep < pt);
  endfunction

  task automatic send(input int mode, input logic [PW-1:0] pt,
                      input logic [NVAR*VW-1:0] vars, input string tag);
    logic [PW-1:0] ep;
    bit ec;
    @(negedge clk);
    in_valid = 1; in_mode = 2'(mode); in_pt = pt; in_vars = vars;
    model(mode, pt, vars, ep, ec);
    q_cyc.push_back(cyc + LAT); q_pt.push_back(ep);
    q_clip.push_back(ec); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 0;
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
        check(0, "R2 missing result", cyc, q_cyc[0]);
        void'(q_cyc.pop_front()); void'(q_pt.pop_front());
        void'(q_clip.pop_front()); void'(q_tag.pop_front());
      end
      if (out_valid) begin
        if (q_cyc.size() == 0) check(0, "R2 unexpected valid", 1, 0);
        else begin
          string t;
          t = q_tag.pop_front();
          check(q_cyc[0] == cyc, "R2 latency", cyc, q_cyc[0]);
          check(out_pt == q_pt[0], {t, " momentum"}, out_pt, q_pt[0]);
          check(out_clip == q_clip[0], "R7 clip flag", out_clip, q_clip[0]);
          void'(q_cyc.pop_front()); void'(q_pt.pop_front()); void'(q_clip.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    finish_run();
  end

  function automatic logic [NVAR*VW-1:0] fill(input logic [VW-1:0] v);
    logic [NVAR*VW-1:0] r;
    for (int j = 0; j < NVAR; j++) r[j*VW +: VW] = v;
    return r;
  endfunction

  initial begin
    int seed;
    logic [NVAR*VW-1:0] vv;
    int lo0, hi3, lo7;
    seed = $urandom(20240517);
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 idle in reset", out_valid, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(out_valid == 0, "R1 idle after reset", out_valid, 0);

    for (int s = 0; s < 3; s++)
      for (int b = 0; b < (1 << PBW); b++)
        for (int v = 0; v < NVAR; v++) begin
          int lo;
          lo = 1 + int'($urandom % 24);
          wr_bound(s, b, v, lo, lo + 8 + int'($urandom % 30));
        end
    for (int v = 0; v < NVAR; v++)
      for (int i = 0; i < (1 << VW); i++)
        wr_mpv(v, i, int'($urandom % 256));

    // R4: values on the bounds are inside (mode 2, bin 5, set 1)
    vv = '0;
    for (int j = 0; j < NVAR; j++) vv[j*VW +: VW] = m_lo[1][5][j];
    send(2, 8'hA0, vv, "R4 at lower bound");
    for (int j = 0; j < NVAR; j++) vv[j*VW +: VW] = m_hi[1][5][j];
    send(2, 8'hA0, vv, "R4 at upper bound");
    idle(LAT + 2);

    // R5: one variable just below its bound
    for (int j = 0; j < NVAR; j++) vv[j*VW +: VW] = m_lo[1][5][j];
    lo0 = int'(m_lo[1][5][0]) - 1;
    vv[0 +: VW] = VW'(lo0);
    wr_mpv(0, lo0, 8'h10);
    send(2, 8'hA0, vv, "R5 demote below bound");
    idle(LAT + 2);
    wr_mpv(0, lo0, 8'hC0);
    send(2, 8'hA0, vv, "R5 higher proposal ignored");
    idle(LAT + 2);

    // R6: several tails, the smallest proposal wins
    hi3 = int'(m_hi[1][5][3]) + 1;
    lo7 = int'(m_lo[1][5][7]) - 1;
    vv[3*VW +: VW] = VW'(hi3);
    vv[7*VW +: VW] = VW'(lo7);
    wr_mpv(3, hi3, 8'h30);
    wr_mpv(7, lo7, 8'h20);
    send(2, 8'hA0, vv, "R6 minimum of tails");
    idle(1);
    // R3: the same candidate with clipping off
    send(0, 8'hA0, vv, "R3 mode off");
    // R8: the same candidate under each bound set
    send(1, 8'hA0, vv, "R8 set wide");
    send(3, 8'hA0, vv, "R8 set tight");
    send(0, 8'hFF, fill(6'd0), "R3 off extreme");
    send(3, 8'hFF, fill(6'd63), "R6 all high tails");
    idle(LAT + 2);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [NVAR*VW-1:0] rv;
      for (int j = 0; j < NVAR; j++) rv[j*VW +: VW] = VW'($urandom);
      send(int'($urandom % 4), PW'($urandom), rv, "R6 random");
      if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
    end
    idle(LAT + 4);
    check(q_cyc.size() == 0, "R2 all results delivered", q_cyc.size(), 0);
    finish_run();
  end

endmodule